// File: doc/BRIEF.md
# Banked Two-Port Data Memory with Conflict Wait State

This block is a 16-bit-wide on-chip data memory that two independent requesters, port X and port Y, can use at the same time. The storage is made of six separate single-port banks of 1024 words each. The bank is chosen by address bits [12:10] and the word inside the bank by bits [9:0]. When the two ports address different banks in the same cycle, both accesses complete in that cycle. When they address the same bank, the block grants one port and makes the other wait exactly one cycle.

Each port has a request line, a write enable, an address, write data, read data and a ready flag. Ready is a same-cycle grant: it goes high during the cycle in which the port's access is carried out. A requester keeps its request and all its inputs steady until it sees ready high. Read data is registered and is valid in the cycle after the cycle in which ready was high. The block claims only word addresses 0x0000 to 0x17FF. For any other address it never raises ready, never touches storage and never takes part in arbitration.

On a same-bank collision after a cycle with no collision, X wins and Y is served in the next cycle. The loser of a collision has priority in the following cycle. This means a new X request that hits the bank of a waiting Y request is the one that waits.

Top module: `banked_dpmem`

## Requirements
- R1: A request to an address in 0x0000..0x17FF raises that port's ready in the same cycle when the other port makes no conflicting request.
- R2: Word address bits [12:10] select one of six banks and bits [9:0] the word inside it. X and Y read and write the same storage, 16 bits per word.
- R3: When both ports request in-range addresses in different banks in one cycle, both ready flags are high in that cycle, with no wait state.
- R4: When both ports request the same bank and neither was left waiting in the previous cycle, X's ready is high and Y's ready is low. If Y holds its request, Y's ready is high in the next cycle.
- R5: The two ready flags are never high together for accesses to the same bank.
- R6: A port that lost a collision wins the next one. A new X request to the bank of a held Y request waits one cycle and is then served.
- R7: If both ports write the same address in one cycle, the word ends up holding Y's data.
- R8: For addresses at or above 0x1800, ready stays low and storage is unchanged. Such a request never stalls the other port.
- R9: Read data appears on the port's read-data output in the cycle after its ready cycle. A read in the cycle right after a write to the same address returns the new value.
- R10: Reset is synchronous and active low. After reset, the first collision is won by X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_req | input | 1 | Port X request, held until x_ready |
| x_we | input | 1 | Port X write enable (1 = write, 0 = read) |
| x_addr | input | 16 | Port X word address |
| x_wdata | input | 16 | Port X write data |
| x_rdata | output | 16 | Port X read data, valid the cycle after x_ready |
| x_ready | output | 1 | Port X access carried out this cycle |
| y_req | input | 1 | Port Y request, held until y_ready |
| y_we | input | 1 | Port Y write enable (1 = write, 0 = read) |
| y_addr | input | 16 | Port Y word address |
| y_wdata | input | 16 | Port Y write data |
| y_rdata | output | 16 | Port Y read data, valid the cycle after y_ready |
| y_ready | output | 1 | Port Y access carried out this cycle |

## Verification
The bench builds the block with its default parameters: 16-bit data, 10-bit bank offset, six banks and a 16-bit address. With these values, the lowest and highest claimed words (0x0000 and 0x17FF in bank 5) and the first unclaimed word (0x1800) can all be tested directly. So can 0x2000, whose low bits would alias bank 0 if the range check were missing. The same configuration lets the bench drive collisions inside one bank, set up the back-to-back case in which a waiting Y request meets a new X request, and run parallel traffic between the two outer banks.

// File: rtl/dpm_pkg.sv
// Package: shared defaults and the per-bank port-selection type.
// Assumes: every bank is driven by at most one port in any cycle.
package dpm_pkg;
    localparam int unsigned DPM_DATA_W    = 16;
    localparam int unsigned DPM_ADDR_W    = 16;
    localparam int unsigned DPM_BANK_AW   = 10;
    localparam int unsigned DPM_NUM_BANKS = 6;

    // Which port owns a bank in the current cycle
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_X    = 2'd1,
        SEL_Y    = 2'd2
    } bank_sel_e;
endpackage

// File: rtl/dpm_decode.sv
// Module: address decoder for one port.
// Splits a word address into bank index and offset and flags whether
// the address lies inside the claimed window [0, NUM_BANKS*2^BANK_AW).
// Assumes: ADDR_W < 32 and BIDX_W wide enough for NUM_BANKS-1.
module dpm_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BANK_AW   = 10,
    parameter int unsigned NUM_BANKS = 6,
    parameter int unsigned BIDX_W    = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [BIDX_W-1:0]  bank,
    output logic [BANK_AW-1:0] off
);
    localparam int unsigned LIMIT = NUM_BANKS * (1 << BANK_AW);

    // Range claim and field split
    always_comb begin
        hit  = (32'(addr) < LIMIT);
        bank = addr[BANK_AW +: BIDX_W];
        off  = addr[BANK_AW-1:0];
    end
endmodule

// File: rtl/dpm_arbiter.sv
// Module: collision arbiter between ports X and Y.
// A collision is two wanting ports on one bank. X wins unless Y lost
// the previous cycle's collision; the loser of any collision holds
// priority for exactly the next cycle.
// Assumes: a losing requester holds its request until granted.
module dpm_arbiter #(
    parameter int unsigned BIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_want,
    input  logic              y_want,
    input  logic [BIDX_W-1:0] x_bank,
    input  logic [BIDX_W-1:0] y_bank,
    output logic              x_gnt,
    output logic              y_gnt
);
    logic pri_y_q;
    logic clash;

    // Grant decision for the current cycle
    always_comb begin
        clash = x_want && y_want && (x_bank == y_bank);
        x_gnt = x_want && !(clash && pri_y_q);
        y_gnt = y_want && !(clash && !pri_y_q);
    end

    // Priority passes to Y only after Y lost a collision
    always_ff @(posedge clk) begin
        if (!rst_n) pri_y_q <= 1'b0;
        else        pri_y_q <= clash && !pri_y_q;
    end
endmodule

// File: rtl/dpm_bank.sv
// Module: one single-port synchronous bank.
// Read data is registered; on a write the old word is returned.
// Assumes: en/we/addr/wdata come from a single owner per cycle.
module dpm_bank #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned AW     = 10
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [1 << AW];

    // Synchronous access of the storage array
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/banked_dpmem.sv
// Module: two-port memory built from NUM_BANKS single-port banks.
// Decodes both ports, arbitrates same-bank collisions, routes each
// bank to its owner and returns registered read data per port.
// Assumes: requesters hold inputs steady until their ready is seen.
module banked_dpmem
    import dpm_pkg::*;
#(
    parameter int unsigned DATA_W    = DPM_DATA_W,
    parameter int unsigned ADDR_W    = DPM_ADDR_W,
    parameter int unsigned BANK_AW   = DPM_BANK_AW,
    parameter int unsigned NUM_BANKS = DPM_NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_req,
    input  logic              x_we,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [DATA_W-1:0] x_wdata,
    output logic [DATA_W-1:0] x_rdata,
    output logic              x_ready,
    input  logic              y_req,
    input  logic              y_we,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [DATA_W-1:0] y_wdata,
    output logic [DATA_W-1:0] y_rdata,
    output logic              y_ready
);
    localparam int unsigned BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic               x_hit, y_hit, x_gnt, y_gnt;
    logic [BIDX_W-1:0]  x_bank, y_bank, x_bank_q, y_bank_q;
    logic [BANK_AW-1:0] x_off, y_off;
    logic [DATA_W-1:0]  bank_rd [NUM_BANKS];

    dpm_decode #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS),
                 .BIDX_W(BIDX_W)) x_dec_i (
        .addr(x_addr), .hit(x_hit), .bank(x_bank), .off(x_off)
    );

    dpm_decode #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS),
                 .BIDX_W(BIDX_W)) y_dec_i (
        .addr(y_addr), .hit(y_hit), .bank(y_bank), .off(y_off)
    );

    dpm_arbiter #(.BIDX_W(BIDX_W)) arb_i (
        .clk(clk), .rst_n(rst_n),
        .x_want(x_req && x_hit), .y_want(y_req && y_hit),
        .x_bank(x_bank), .y_bank(y_bank),
        .x_gnt(x_gnt), .y_gnt(y_gnt)
    );

    // Ready is the grant itself
    always_comb begin
        x_ready = x_gnt;
        y_ready = y_gnt;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_sel_e          sel;
        logic               en, we;
        logic [BANK_AW-1:0] addr;
        logic [DATA_W-1:0]  wdata;

        // Route the owning port onto this bank
        always_comb begin
            if (y_gnt && (y_bank == BIDX_W'(b)))      sel = SEL_Y;
            else if (x_gnt && (x_bank == BIDX_W'(b))) sel = SEL_X;
            else                                      sel = SEL_NONE;
            en    = (sel != SEL_NONE);
            we    = (sel == SEL_Y) ? y_we    : x_we;
            addr  = (sel == SEL_Y) ? y_off   : x_off;
            wdata = (sel == SEL_Y) ? y_wdata : x_wdata;
        end

        dpm_bank #(.DATA_W(DATA_W), .AW(BANK_AW)) bank_i (
            .clk(clk), .en(en), .we(we), .addr(addr),
            .wdata(wdata), .rdata(bank_rd[b])
        );
    end

    // Remember which bank each port used on its last grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_bank_q <= '0;
            y_bank_q <= '0;
        end else begin
            if (x_gnt) x_bank_q <= x_bank;
            if (y_gnt) y_bank_q <= y_bank;
        end
    end

    // Select the registered bank output for each port
    always_comb begin
        x_rdata = '0;
        y_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (x_bank_q == BIDX_W'(b)) x_rdata = bank_rd[b];
            if (y_bank_q == BIDX_W'(b)) y_rdata = bank_rd[b];
        end
    end
endmodule

// File: rtl/dpm_checker.sv
// Module: protocol checker bound to banked_dpmem.
// Observes port-level behaviour only and recomputes range and bank
// from the addresses seen on the ports.
// Assumes: requesters hold inputs steady until ready.
module dpm_checker #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BANK_AW   = 10,
    parameter int unsigned NUM_BANKS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              x_req,
    input logic [ADDR_W-1:0] x_addr,
    input logic              x_ready,
    input logic              y_req,
    input logic [ADDR_W-1:0] y_addr,
    input logic              y_ready
);
    localparam int unsigned LIMIT = NUM_BANKS * (1 << BANK_AW);

    logic x_in, y_in, same_bk;

    // Port-side view of range and bank equality
    always_comb begin
        x_in    = (32'(x_addr) < LIMIT);
        y_in    = (32'(y_addr) < LIMIT);
        same_bk = (x_addr >> BANK_AW) == (y_addr >> BANK_AW);
    end

    AST_X_ALONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        x_req && x_in && !y_req |-> x_ready); // R1
    AST_PARALLEL_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        x_req && y_req && x_in && y_in && !same_bk |-> x_ready && y_ready); // R3
    AST_Y_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (y_req && y_in && !y_ready) ##1 (y_req && $stable(y_addr)) |-> y_ready); // R4
    AST_NO_SHARED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        x_ready && y_ready |-> !same_bk); // R5
    AST_X_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (x_req && x_in && !x_ready) ##1 (x_req && $stable(x_addr)) |-> x_ready); // R6
    AST_X_OOR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        x_req && !x_in |-> !x_ready); // R8
    AST_Y_OOR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        y_req && !y_in |-> !y_ready); // R8
endmodule

bind banked_dpmem dpm_checker #(
    .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .x_req(x_req), .x_addr(x_addr), .x_ready(x_ready),
    .y_req(y_req), .y_addr(y_addr), .y_ready(y_ready)
);

// File: tb/banked_dpmem_tb_top.sv
// Bench: directed scenarios for banked_dpmem, one task per scenario.
// Inputs change just after the falling edge; ready is sampled 1 time
// unit later in the same cycle; read data is sampled at the next
// falling edge.
module banked_dpmem_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        x_req, x_we, y_req, y_we;
    logic [15:0] x_addr, x_wdata, y_addr, y_wdata;
    logic [15:0] x_rdata, y_rdata;
    logic        x_ready, y_ready;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    banked_dpmem dut_i (
        .clk(clk), .rst_n(rst_n),
        .x_req(x_req), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata),
        .x_rdata(x_rdata), .x_ready(x_ready),
        .y_req(y_req), .y_we(y_we), .y_addr(y_addr), .y_wdata(y_wdata),
        .y_rdata(y_rdata), .y_ready(y_ready)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_x(input logic r, input logic w, input logic [15:0] a, input logic [15:0] d);
        x_req = r; x_we = w; x_addr = a; x_wdata = d;
    endtask

    task automatic set_y(input logic r, input logic w, input logic [15:0] a, input logic [15:0] d);
        y_req = r; y_we = w; y_addr = a; y_wdata = d;
    endtask

    task automatic idle_both();
        set_x(1'b0, 1'b0, 16'h0, 16'h0);
        set_y(1'b0, 1'b0, 16'h0, 16'h0);
    endtask

    task automatic rd_x(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); set_x(1'b1, 1'b0, a, 16'h0);
        #1 chk({tag, " x read ready"}, 16'(x_ready), 16'h1);
        @(negedge clk); set_x(1'b0, 1'b0, 16'h0, 16'h0);
        chk({tag, " x read data"}, x_rdata, exp);
    endtask

    task automatic rd_y(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); set_y(1'b1, 1'b0, a, 16'h0);
        #1 chk({tag, " y read ready"}, 16'(y_ready), 16'h1);
        @(negedge clk); set_y(1'b0, 1'b0, 16'h0, 16'h0);
        chk({tag, " y read data"}, y_rdata, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle_both();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset x_ready", 16'(x_ready), 16'h0);
        chk("R10 reset y_ready", 16'(y_ready), 16'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_clash();
        @(negedge clk);
        set_x(1'b1, 1'b1, 16'h0405, 16'h1111);
        set_y(1'b1, 1'b1, 16'h0409, 16'h2222);
        #1 chk("R4 R10 x wins first clash", 16'(x_ready), 16'h1);
        chk("R4 y waits", 16'(y_ready), 16'h0);
        @(negedge clk); set_x(1'b0, 1'b0, 16'h0, 16'h0);
        #1 chk("R4 y served next cycle", 16'(y_ready), 16'h1);
        @(negedge clk); idle_both();
        rd_x(16'h0409, 16'h2222, "R2 shared storage");
        rd_y(16'h0405, 16'h1111, "R2 shared storage");
    endtask

    task automatic t_parallel();
        @(negedge clk);
        set_x(1'b1, 1'b1, 16'h0000, 16'hA5A5);
        set_y(1'b1, 1'b1, 16'h17FF, 16'h5A5A);
        #1 chk("R3 x parallel write", 16'(x_ready), 16'h1);
        chk("R3 y parallel write", 16'(y_ready), 16'h1);
        @(negedge clk);
        set_x(1'b1, 1'b0, 16'h17FF, 16'h0);
        set_y(1'b1, 1'b0, 16'h0000, 16'h0);
        #1 chk("R3 x parallel read", 16'(x_ready), 16'h1);
        chk("R3 y parallel read", 16'(y_ready), 16'h1);
        @(negedge clk); idle_both();
        chk("R9 R2 x reads bank5 top", x_rdata, 16'h5A5A);
        chk("R9 R2 y reads bank0 base", y_rdata, 16'hA5A5);
    endtask

    task automatic t_same_addr();
        @(negedge clk);
        set_x(1'b1, 1'b1, 16'h0123, 16'hAAAA);
        set_y(1'b1, 1'b1, 16'h0123, 16'h5555);
        #1 chk("R7 x write first", 16'(x_ready), 16'h1);
        @(negedge clk); set_x(1'b0, 1'b0, 16'h0, 16'h0);
        #1 chk("R7 y write second", 16'(y_ready), 16'h1);
        @(negedge clk); idle_both();
        rd_x(16'h0123, 16'h5555, "R7 y value kept");
    endtask

    task automatic t_owed();
        @(negedge clk);
        set_x(1'b1, 1'b1, 16'h0800, 16'h3333);
        set_y(1'b1, 1'b1, 16'h0801, 16'h4444);
        #1 chk("R6 clash x first", 16'(x_ready), 16'h1);
        @(negedge clk); set_x(1'b1, 1'b1, 16'h0802, 16'h7777);
        #1 chk("R6 owed y wins", 16'(y_ready), 16'h1);
        chk("R6 new x waits", 16'(x_ready), 16'h0);
        @(negedge clk); set_y(1'b0, 1'b0, 16'h0, 16'h0);
        #1 chk("R6 x served after one wait", 16'(x_ready), 16'h1);
        @(negedge clk); idle_both();
        rd_y(16'h0802, 16'h7777, "R6 x write landed");
        rd_x(16'h0801, 16'h4444, "R6 y write landed");
    endtask

    task automatic t_range();
        @(negedge clk);
        set_x(1'b1, 1'b1, 16'h1800, 16'hDEAD);
        set_y(1'b1, 1'b1, 16'h2000, 16'hBEEF);
        #1 chk("R8 x 0x1800 not claimed", 16'(x_ready), 16'h0);
        chk("R8 y 0x2000 not claimed", 16'(y_ready), 16'h0);
        @(negedge clk);
        set_x(1'b1, 1'b1, 16'h0010, 16'h0F0F);
        set_y(1'b1, 1'b1, 16'h2010, 16'hFFFF);
        #1 chk("R8 x not stalled by unclaimed y", 16'(x_ready), 16'h1);
        chk("R8 y 0x2010 not claimed", 16'(y_ready), 16'h0);
        @(negedge clk); idle_both();
        rd_x(16'h0000, 16'hA5A5, "R8 alias word unchanged");
        rd_y(16'h0010, 16'h0F0F, "R8 alias word unchanged");
        rd_x(16'h17FF, 16'h5A5A, "R1 top word");
    endtask

    task automatic t_raw();
        @(negedge clk);
        set_x(1'b1, 1'b1, 16'h0C00, 16'h1234);
        #1 chk("R1 lone write ready", 16'(x_ready), 16'h1);
        @(negedge clk); set_x(1'b1, 1'b0, 16'h0C00, 16'h0);
        #1 chk("R9 read after write ready", 16'(x_ready), 16'h1);
        @(negedge clk); idle_both();
        chk("R9 read after write data", x_rdata, 16'h1234);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        t_reset();
        t_first_clash();
        t_parallel();
        t_same_addr();
        t_owed();
        t_range();
        t_raw();
        repeat (2) @(negedge clk);
        report();
    end
endmodule